// File: doc/BRIEF.md
# Counter Gate Sequencer

This block produces the counting window and the end-of-window strobes for a universal counter clocked from a 10 MHz reference. A chain of decade prescalers divides the reference to form either a long gate (one second) or a short gate (one millisecond). A range input picks between them. A mode input then decides which signal gates which.

- **Frequency mode:** synchronized input edges are counted while the time-base window is open.
- **Period mode:** the window spans one full input period, and the counted events are prescaler ticks.
- **Totalize mode:** the window stays open and every input edge is counted.

The block drives a single-cycle count enable toward an external counter bank. When a gate closes, it issues a transfer strobe so that the count can be latched. A clear strobe follows one cycle later, and the next window opens only after that clear. Any change of mode or range abandons the window in progress, issues no transfer strobe, and starts again from the arm state.

Top module: `cnt_gate_seq`

## Requirements
- R1: While `rst_n` is low, `gate_on`, `count_en`, `xfer_stb` and `clr_stb` are all low.
- R2: In frequency mode (`mode_sel` = 0) with `range_sel` = 0, each completed gate keeps `gate_on` high for exactly DIV^STG_MS consecutive clock cycles (10,000 cycles by default, which is 1 ms).
- R3: In frequency mode with `range_sel` = 1, each completed gate keeps `gate_on` high for exactly DIV^STG_S consecutive cycles (10,000,000 cycles by default, which is 1 s).
- R4: In frequency mode, `count_en` pulses for one cycle per rising edge of `sig_in`, and only while `gate_on` is high.
- R5: The cycle after the last gate cycle has `xfer_stb` high for one cycle. The next cycle has `clr_stb` high for one cycle. There follows one arm cycle with all outputs low, and after that the next gate opens.
- R6: In period mode (`mode_sel` = 1), `gate_on` rises in the cycle after a synchronized rising input edge and stays high through the cycle of the next one. Its length therefore equals the input period in clock cycles.
- R7: In period mode, `count_en` pulses once every DIV^PER_STAGES gate cycles, measured from the opening of the gate. A gate of P cycles therefore yields floor(P / DIV^PER_STAGES) pulses.
- R8: In totalize mode (`mode_sel` = 2 or 3), `gate_on` stays high after a single arm cycle, `xfer_stb` and `clr_stb` never pulse, and `count_en` pulses once per rising input edge.
- R9: Any change of `mode_sel` or `range_sel` sends the block to the arm state on the next clock edge, with no transfer strobe. A fresh gate of the new length then follows, so the next `xfer_stb` appears exactly 1 + gate-length + 1 cycles after the change is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (10 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Conditioned asynchronous input signal |
| mode_sel | input | 2 | 0 frequency, 1 period, 2 or 3 totalize |
| range_sel | input | 1 | 0 short gate, 1 long gate |
| gate_on | output | 1 | High while the counting window is open |
| count_en | output | 1 | Single-cycle count enable toward the counters |
| xfer_stb | output | 1 | Transfer strobe after a gate closes |
| clr_stb | output | 1 | Clear strobe, one cycle after the transfer strobe |

## Verification
The bench runs with a shortened divide ratio so that gate lengths can be measured cycle by cycle. An off-by-one in the prescaler terminal or in the chain clear would show up as a gate one cycle long or one cycle short.

In period mode, the bench checks that the window covers the full period and that the tick count matches floor(P/M). A design that opened on the edge cycle itself, or that let the prescaler run free during the wait, would give the wrong tick count.

The bench also changes the range in mid-gate and expects no transfer strobe before the new full-length window. A design that let the abort fall through would produce a stray transfer or a truncated gate. Finally, the bench confirms that the clear strobe always follows the transfer strobe by exactly one cycle, and that totalize mode never emits a strobe.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

   typedef enum logic [1:0] {
      ST_ARM  = 2'd0,
      ST_OPEN = 2'd1,
      ST_XFER = 2'd2,
      ST_CLR  = 2'd3
   } seq_state_e;

   typedef enum logic [1:0] {
      MD_FREQ   = 2'd0,
      MD_PERIOD = 2'd1,
      MD_TOTAL  = 2'd2,
      MD_TOTAL2 = 2'd3
   } mode_e;

   function automatic logic is_total(input logic [1:0] m);
      return m[1];
   endfunction

endpackage

// File: rtl/cgs_edge_sync.sv
module cgs_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_pulse
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("cgs_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise_pulse = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/cgs_decade_chain.sv
module cgs_decade_chain #(
   parameter int DIV  = 10,
   parameter int NSTG = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   output logic [NSTG-1:0] carry
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] TOP = CW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("cgs_decade_chain: DIV must be at least 2");
   end
   if (NSTG < 1) begin : g_bad_nstg
      $error("cgs_decade_chain: NSTG must be at least 1");
   end

   for (genvar i = 0; i < NSTG; i++) begin : g_stg
      logic [CW-1:0] cnt_q;
      logic          step;
      logic          co;

      if (i == 0) begin : g_first
         assign step = 1'b1;
      end else begin : g_next
         assign step = g_stg[i-1].co;
      end

      assign co       = step & (cnt_q == TOP);
      assign carry[i] = co;

      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            cnt_q <= '0;
         end else if (step) begin
            cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cgs_seq_fsm.sv
module cgs_seq_fsm
   import cgs_pkg::*;
#(
   parameter int NSTG       = 7,
   parameter int STG_MS     = 4,
   parameter int STG_S      = 7,
   parameter int PER_STAGES = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      mode_sel,
   input  logic            range_sel,
   input  logic            edge_p,
   input  logic [NSTG-1:0] carry,
   output logic            chain_clr,
   output logic            gate_on,
   output logic            count_en,
   output logic            xfer_stb,
   output logic            clr_stb
);
   seq_state_e state_q, state_d;
   logic [1:0] mode_q;
   logic       range_q;
   logic       abort;
   logic       gate_done;
   logic       tick;
   logic       event_p;
   logic       unused_carry;

   assign unused_carry = ^carry;
   assign abort        = (mode_sel != mode_q) || (range_sel != range_q);
   assign gate_done    = range_q ? carry[STG_S-1] : carry[STG_MS-1];
   assign tick         = carry[PER_STAGES-1];
   assign event_p      = (mode_q == MD_PERIOD) ? tick : edge_p;

   always_comb begin
      state_d = state_q;
      if (abort) begin
         state_d = ST_ARM;
      end else begin
         case (state_q)
            ST_ARM: begin
               if (mode_q != MD_PERIOD || edge_p) state_d = ST_OPEN;
            end
            ST_OPEN: begin
               if (mode_q == MD_FREQ && gate_done)        state_d = ST_XFER;
               else if (mode_q == MD_PERIOD && edge_p)    state_d = ST_XFER;
            end
            ST_XFER: state_d = ST_CLR;
            default: state_d = ST_ARM;
         endcase
         if (is_total(mode_q) && state_q != ST_ARM) state_d = ST_OPEN;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_ARM;
         mode_q  <= MD_FREQ;
         range_q <= 1'b0;
      end else begin
         state_q <= state_d;
         mode_q  <= mode_sel;
         range_q <= range_sel;
      end
   end

   assign chain_clr = (state_q == ST_ARM);
   assign gate_on   = (state_q == ST_OPEN);
   assign xfer_stb  = (state_q == ST_XFER);
   assign clr_stb   = (state_q == ST_CLR);
   assign count_en  = gate_on & event_p;
endmodule

// File: rtl/cnt_gate_seq.sv
module cnt_gate_seq #(
   parameter int DIV         = 10,
   parameter int STG_MS      = 4,
   parameter int STG_S       = 7,
   parameter int PER_STAGES  = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sig_in,
   input  logic [1:0] mode_sel,
   input  logic       range_sel,
   output logic       gate_on,
   output logic       count_en,
   output logic       xfer_stb,
   output logic       clr_stb
);
   localparam int NSTG = (STG_S > STG_MS) ? STG_S : STG_MS;

   if (STG_MS < 1 || STG_S <= STG_MS) begin : g_bad_range
      $error("cnt_gate_seq: need 1 <= STG_MS < STG_S");
   end
   if (PER_STAGES < 1 || PER_STAGES > NSTG) begin : g_bad_per
      $error("cnt_gate_seq: PER_STAGES out of range");
   end

   logic            edge_p;
   logic            chain_clr;
   logic [NSTG-1:0] carry;

   cgs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (sig_in),
      .rise_pulse (edge_p)
   );

   cgs_decade_chain #(.DIV(DIV), .NSTG(NSTG)) i_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (chain_clr),
      .carry (carry)
   );

   cgs_seq_fsm #(
      .NSTG(NSTG), .STG_MS(STG_MS), .STG_S(STG_S), .PER_STAGES(PER_STAGES)
   ) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_sel  (mode_sel),
      .range_sel (range_sel),
      .edge_p    (edge_p),
      .carry     (carry),
      .chain_clr (chain_clr),
      .gate_on   (gate_on),
      .count_en  (count_en),
      .xfer_stb  (xfer_stb),
      .clr_stb   (clr_stb)
   );
endmodule

// File: rtl/cgs_chk.sv
module cgs_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_sel,
   input logic       range_sel,
   input logic       gate_on,
   input logic       count_en,
   input logic       xfer_stb,
   input logic       clr_stb
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !rst_n || (!gate_on && !xfer_stb && !clr_stb && !count_en));

   // R5
   xfer_then_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_stb && $stable(mode_sel) && $stable(range_sel) |=> clr_stb);

   // R5
   clr_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |-> $past(xfer_stb));

   // R5
   xfer_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_stb |-> $past(gate_on));

   // R5
   exclusive_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gate_on, xfer_stb, clr_stb}));

   // R4
   enable_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_en |-> gate_on);

   // R9
   abort_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel != $past(mode_sel)) || (range_sel != $past(range_sel)) |=> !xfer_stb);
endmodule

bind cnt_gate_seq cgs_chk i_cgs_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_sel  (mode_sel),
   .range_sel (range_sel),
   .gate_on   (gate_on),
   .count_en  (count_en),
   .xfer_stb  (xfer_stb),
   .clr_stb   (clr_stb)
);

// File: tb/test_cnt_gate_seq.sv
module test_cnt_gate_seq;
   localparam int DIV = 2, STG_MS = 3, STG_S = 6, PER = 1;
   localparam int N_FAST = 8, N_SLOW = 64, TICK = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sig_in = 1'b0;
   logic [1:0] mode_sel = 2'd0;
   logic range_sel = 1'b0;
   logic gate_on, count_en, xfer_stb, clr_stb;

   int n_chk = 0, n_bad = 0;
   int sig_half = 0;
   bit done = 1'b0;

   cnt_gate_seq #(.DIV(DIV), .STG_MS(STG_MS), .STG_S(STG_S), .PER_STAGES(PER)) i_cnt_gate_seq (
      .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .mode_sel(mode_sel),
      .range_sel(range_sel), .gate_on(gate_on), .count_en(count_en),
      .xfer_stb(xfer_stb), .clr_stb(clr_stb)
   );

   always #4 clk = ~clk;

   initial begin : sig_gen
      int ph = 0;
      forever begin
         @(negedge clk);
         if (sig_half > 0) begin
            if (ph >= sig_half - 1) begin
               sig_in = ~sig_in;
               ph = 0;
            end else ph++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic wait_xfer(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 400 && !seen; i++) begin
         @(negedge clk);
         seen = xfer_stb;
      end
   endtask

   // measure gate after a clr/arm pair; returns gate length and enable count
   task automatic measure_gate(output int glen, output int ens, output bit stray);
      glen = 0; ens = 0; stray = 1'b0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (xfer_stb) break;
         if (gate_on) glen++;
         if (count_en) ens++;
         if (count_en && !gate_on) stray = 1'b1;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!gate_on && !count_en && !xfer_stb && !clr_stb, "R1 reset outputs", 
          int'({gate_on, count_en, xfer_stb, clr_stb}), 0);
   endtask

   task automatic t_freq(input bit rng, input int half, input int exp_len, input string req);
      bit seen; int glen, ens, lo, hi; bit stray;
      mode_sel = 2'd0; range_sel = rng; sig_half = half;
      wait_xfer(seen);
      chk(seen, {req, " first xfer"}, int'(seen), 1);
      @(negedge clk);
      chk(clr_stb && !xfer_stb, "R5 clr follows xfer", int'(clr_stb), 1);
      @(negedge clk);
      chk(!gate_on && !clr_stb && !xfer_stb, "R5 arm cycle idle", int'(gate_on), 0);
      measure_gate(glen, ens, stray);
      chk(glen == exp_len, {req, " gate length"}, glen, exp_len);
      lo = exp_len / (2 * half) - 1; hi = exp_len / (2 * half) + 1;
      chk(ens >= lo && ens <= hi && !stray, "R4 edge count in gate", ens, exp_len / (2 * half));
   endtask

   task automatic t_period(input int half);
      bit seen; int glen, ens; bit stray;
      mode_sel = 2'd1; range_sel = 1'b0; sig_half = half;
      wait_xfer(seen);
      @(negedge clk);
      chk(clr_stb, "R5 clr after period xfer", int'(clr_stb), 1);
      measure_gate(glen, ens, stray);
      chk(glen == 2 * half, "R6 period gate length", glen, 2 * half);
      chk(ens == (2 * half) / TICK && !stray, "R7 period tick count", ens, (2 * half) / TICK);
   endtask

   task automatic t_total();
      int ens = 0; bit bad = 1'b0;
      mode_sel = 2'd2; sig_half = 2;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (!gate_on || xfer_stb || clr_stb) bad = 1'b1;
         if (count_en) ens++;
      end
      chk(!bad, "R8 totalize gate held, no strobes", int'(bad), 0);
      chk(ens >= 24 && ens <= 26, "R8 totalize edge count", ens, 25);
   endtask

   task automatic t_abort();
      bit seen; int gl = 0, n = 0;
      mode_sel = 2'd0; range_sel = 1'b1; sig_half = 3;
      wait_xfer(seen);
      repeat (14) @(negedge clk);
      chk(gate_on, "R9 mid-gate before change", int'(gate_on), 1);
      range_sel = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         n++;
         if (xfer_stb) break;
         if (gate_on) gl++;
      end
      chk(n == N_FAST + 2, "R9 xfer delay after abort", n, N_FAST + 2);
      chk(gl == N_FAST, "R9 restarted gate length", gl, N_FAST);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin : main
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_freq(1'b0, 1, N_FAST, "R2");
      t_freq(1'b0, 2, N_FAST, "R2");
      t_freq(1'b1, 2, N_SLOW, "R3");
      t_period(3);
      t_period(5);
      t_total();
      t_abort();
      summary();
   end
endmodule